// File: doc/BRIEF.md
# Load-Use Stall and Operand Bypass Control

This block is the purely combinational hazard controller of a five-stage in-order integer pipeline. Each cycle it compares the source register numbers of the instructions in decode and execute with the destination register, write enable and load flag of the instructions further down the pipe. From that comparison it picks where each execute-stage ALU operand comes from, and it decides whether decode must wait for a load.

There are two bypass points. One is the execute/memory boundary, which holds the result of the previous instruction. The other is the memory/writeback boundary, which holds the result from two instructions back, loaded data included. When both points hold a value for the same register, the younger one wins. A result that is being written back needs no bypass, because the register file writes early in the cycle and reads late.

When the instruction in execute is a load whose target is read by the instruction in decode, the block raises a stall. The stall freezes the program counter and the fetch/decode register. It also replaces the control word entering the decode/execute register with all zeros, which produces a bubble. Older instructions keep moving, so the stall ends by itself after one cycle. The consumer then takes the loaded value from the memory/writeback bypass.

Top module: `hazard_ctrl`

## Requirements
- R1: `load_stall` is 1 exactly when `exe_load` and `exe_wen` are both 1, `exe_dst` is nonzero, and `exe_dst` equals `dec_src1` or `dec_src2`.
- R2: `pc_freeze` and `fd_freeze` both equal `load_stall` in every input combination.
- R3: `exe_ctrl_next` is all zeros while `load_stall` is 1, and equals `dec_ctrl` otherwise.
- R4: An operand select is 2'b10 (execute/memory bypass) when `mem_wen` is 1, `mem_dst` is nonzero, and `mem_dst` equals that operand's execute source.
- R5: An operand select is 2'b01 (memory/writeback bypass) when `wb_wen` is 1, `wb_dst` is nonzero and equals the source, and the execute/memory point does not match under R4.
- R6: When both bypass points match the same source, the select is 2'b10.
- R7: A producer whose write enable is 0 never causes a bypass or a stall, even when its destination matches.
- R8: A destination of register 0 never causes a bypass or a stall.
- R9: In all other cases the select is 2'b00, meaning the register file value is used, and the code 2'b11 never appears.
- R10: In a running pipeline, a load followed at once by a consumer of its result stalls for exactly one cycle. The consumer then reaches execute with select 2'b01 for that operand. Later consumers take the younger execute/memory result when they have the choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src1 | input | REG_W | First source register of the instruction in decode |
| dec_src2 | input | REG_W | Second source register of the instruction in decode |
| exe_src1 | input | REG_W | First source register of the instruction in execute |
| exe_src2 | input | REG_W | Second source register of the instruction in execute |
| exe_dst | input | REG_W | Destination held in the decode/execute register |
| exe_wen | input | 1 | Register write enable held in the decode/execute register |
| exe_load | input | 1 | Memory read flag held in the decode/execute register |
| mem_dst | input | REG_W | Destination held in the execute/memory register |
| mem_wen | input | 1 | Register write enable held in the execute/memory register |
| wb_dst | input | REG_W | Destination held in the memory/writeback register |
| wb_wen | input | 1 | Register write enable held in the memory/writeback register |
| dec_ctrl | input | CTRL_W | Control word decoded for the instruction in decode |
| opa_sel | output | 2 | Source select for ALU operand A |
| opb_sel | output | 2 | Source select for ALU operand B |
| load_stall | output | 1 | Load-use stall request |
| pc_freeze | output | 1 | Blocks the program counter write |
| fd_freeze | output | 1 | Blocks the fetch/decode register write |
| exe_ctrl_next | output | CTRL_W | Control word to load into the decode/execute register |

## Verification
On every evaluation the assertions check that the two freeze outputs track the stall and that a stall always carries an all-zero control word. They also check that register 0, or a pipe with no writers, yields the register file select, that no illegal select code appears, and that a stall only comes from a writing load. The exact choice between the two bypass points, and the full truth of the stall condition, are shown by the bench's exhaustive sweeps. Only the bench's small pipeline run can show that the stall lasts one cycle and that the held consumer then picks up the loaded value through the writeback bypass.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB_BYP  = 2'b01,
    SEL_MEM_BYP = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/hz_operand_bypass.sv
module hz_operand_bypass
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output opnd_sel_e        sel
);
  // A producer counts only if it writes a real (nonzero) register equal to src.
  function automatic logic live_match(input logic wen, input logic [REG_W-1:0] dst,
                                      input logic [REG_W-1:0] s);
    return wen && (dst != '0) && (dst == s);
  endfunction

  logic mem_hit;
  logic wb_hit;

  assign mem_hit = live_match(mem_wen, mem_dst, src);
  assign wb_hit  = live_match(wb_wen, wb_dst, src);

  // Youngest producer first.
  always_comb begin
    if (mem_hit)     sel = SEL_MEM_BYP;
    else if (wb_hit) sel = SEL_WB_BYP;
    else             sel = SEL_REGFILE;
  end

  always_comb begin
    assert_legal_code_R9: assert (sel != opnd_sel_e'(2'b11))
      else $error("illegal bypass select");
    assert_reg0_no_bypass_R8: assert (src != '0 || sel == SEL_REGFILE)
      else $error("register 0 was bypassed");
    assert_no_writer_R7: assert (mem_wen || wb_wen || sel == SEL_REGFILE)
      else $error("bypass chosen with no writer in flight");
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src,
  input  logic [REG_W-1:0]              exe_dst,
  input  logic                          exe_wen,
  input  logic                          exe_load,
  output logic                          stall
);
  logic             producer_ok;
  logic [NUM_SRC-1:0] src_hit;

  assign producer_ok = exe_load && exe_wen && (exe_dst != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = producer_ok && (dec_src[g] == exe_dst);
  end

  assign stall = |src_hit;

  always_comb begin
    assert_stall_needs_load_R1: assert (!stall || (exe_load && exe_wen))
      else $error("stall without a writing load in execute");
    assert_stall_reg0_R8: assert (!stall || exe_dst != '0)
      else $error("stall on register 0");
  end
endmodule

// File: rtl/hz_bubble_mux.sv
module hz_bubble_mux #(
  parameter int CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic              squash,
  output logic [CTRL_W-1:0] ctrl_out
);
  assign ctrl_out = squash ? '0 : ctrl_in;
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int CTRL_W = 8
) (
  input  logic [REG_W-1:0]  dec_src1,
  input  logic [REG_W-1:0]  dec_src2,
  input  logic [REG_W-1:0]  exe_src1,
  input  logic [REG_W-1:0]  exe_src2,
  input  logic [REG_W-1:0]  exe_dst,
  input  logic              exe_wen,
  input  logic              exe_load,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_wen,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_wen,
  input  logic [CTRL_W-1:0] dec_ctrl,
  output logic [1:0]        opa_sel,
  output logic [1:0]        opb_sel,
  output logic              load_stall,
  output logic              pc_freeze,
  output logic              fd_freeze,
  output logic [CTRL_W-1:0] exe_ctrl_next
);
  localparam int NUM_OPND = 2;

  logic [NUM_OPND-1:0][REG_W-1:0] exe_srcs;
  logic [NUM_OPND-1:0][REG_W-1:0] dec_srcs;
  opnd_sel_e                      sel_vec [NUM_OPND];

  assign exe_srcs = {exe_src2, exe_src1};
  assign dec_srcs = {dec_src2, dec_src1};

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    hz_operand_bypass #(.REG_W(REG_W)) u_byp (
      .src     (exe_srcs[g]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (sel_vec[g])
    );
  end

  assign opa_sel = sel_vec[0];
  assign opb_sel = sel_vec[1];

  hz_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_OPND)) u_lu (
    .dec_src  (dec_srcs),
    .exe_dst  (exe_dst),
    .exe_wen  (exe_wen),
    .exe_load (exe_load),
    .stall    (load_stall)
  );

  assign pc_freeze = load_stall;
  assign fd_freeze = load_stall;

  hz_bubble_mux #(.CTRL_W(CTRL_W)) u_bub (
    .ctrl_in  (dec_ctrl),
    .squash   (load_stall),
    .ctrl_out (exe_ctrl_next)
  );

  always_comb begin
    assert_freeze_pair_R2: assert (pc_freeze == load_stall && fd_freeze == load_stall)
      else $error("freeze outputs disagree with stall");
    assert_bubble_zero_R3: assert (!load_stall || exe_ctrl_next == '0)
      else $error("stall without bubble");
  end
endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb_top;
  localparam int RW = 3;
  localparam int CW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [RW-1:0] dec_src1, dec_src2, exe_src1, exe_src2, exe_dst, mem_dst, wb_dst;
  logic          exe_wen, exe_load, mem_wen, wb_wen;
  logic [CW-1:0] dec_ctrl;
  logic [1:0]    opa_sel, opb_sel;
  logic          load_stall, pc_freeze, fd_freeze;
  logic [CW-1:0] exe_ctrl_next;

  int tests = 0;
  int fails = 0;

  hazard_ctrl #(.REG_W(RW), .CTRL_W(CW)) dut_i (
    .dec_src1(dec_src1), .dec_src2(dec_src2), .exe_src1(exe_src1), .exe_src2(exe_src2),
    .exe_dst(exe_dst), .exe_wen(exe_wen), .exe_load(exe_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .dec_ctrl(dec_ctrl), .opa_sel(opa_sel), .opb_sel(opb_sel),
    .load_stall(load_stall), .pc_freeze(pc_freeze), .fd_freeze(fd_freeze),
    .exe_ctrl_next(exe_ctrl_next)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench view: rank each candidate source; lower rank wins, 3 means none.
  function automatic int want_sel(input int s, input int md, input int mw, input int wd, input int ww);
    int rank_mem, rank_wb;
    rank_mem = (mw == 1 && md == s && s > 0) ? 1 : 3;
    rank_wb  = (ww == 1 && wd == s && s > 0) ? 2 : 3;
    if (rank_mem < rank_wb) return 2;
    if (rank_wb < 3) return 1;
    return 0;
  endfunction

  function automatic string tag_of(input int s, input int md, input int mw, input int wd, input int ww);
    if ((md == s || wd == s) && s == 0) return "R8";
    if ((md == s && mw == 0) || (wd == s && ww == 0)) return "R7";
    if (md == s && wd == s) return "R6";
    if (md == s) return "R4";
    if (wd == s) return "R5";
    return "R9";
  endfunction

  typedef struct packed {
    logic          v;
    logic [RW-1:0] rd, rs1, rs2;
    logic          we, ld;
  } instr_t;

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    dec_src1 = '0; dec_src2 = '0; exe_src1 = '0; exe_src2 = '0;
    exe_dst = '0; mem_dst = '0; wb_dst = '0;
    exe_wen = 0; exe_load = 0; mem_wen = 0; wb_wen = 0; dec_ctrl = '0;
    @(negedge clk);
    // Idle state: everything quiet.
    check("R9 idle opa", opa_sel, 0);
    check("R9 idle opb", opb_sel, 0);
    check("R1 idle stall", load_stall, 0);
    check("R2 idle freeze", {pc_freeze, fd_freeze}, 0);

    // Exhaustive bypass sweep.
    for (int v = 0; v < (1 << 14); v++) begin
      int a, b, md, mw, wd, ww;
      a  = v & 7;         b  = (v >> 3) & 7;
      md = (v >> 6) & 7;  mw = (v >> 9) & 1;
      wd = (v >> 10) & 7; ww = (v >> 13) & 1;
      exe_src1 = a[RW-1:0]; exe_src2 = b[RW-1:0];
      mem_dst = md[RW-1:0]; mem_wen = mw[0];
      wb_dst = wd[RW-1:0];  wb_wen = ww[0];
      #1;
      check({tag_of(a, md, mw, wd, ww), " opa"}, opa_sel, want_sel(a, md, mw, wd, ww));
      check({tag_of(b, md, mw, wd, ww), " opb"}, opb_sel, want_sel(b, md, mw, wd, ww));
    end
    mem_wen = 0; wb_wen = 0;

    // Exhaustive load-use sweep with a varying control word.
    for (int v = 0; v < (1 << 11); v++) begin
      int s1, s2, ed, ew, el, exp_st;
      logic [CW-1:0] cw;
      s1 = v & 7; s2 = (v >> 3) & 7; ed = (v >> 6) & 7;
      ew = (v >> 9) & 1; el = (v >> 10) & 1;
      cw = CW'((v * 37 + 11) | 1);
      dec_src1 = s1[RW-1:0]; dec_src2 = s2[RW-1:0]; exe_dst = ed[RW-1:0];
      exe_wen = ew[0]; exe_load = el[0]; dec_ctrl = cw;
      exp_st = (ew + el == 2 && ed != 0 && (s1 == ed || s2 == ed)) ? 1 : 0;
      #1;
      if (ed == 0 && (s1 == 0 || s2 == 0) && ew + el == 2) check("R8 stall", load_stall, exp_st);
      else if (ew == 0 && el == 1) check("R7 stall", load_stall, exp_st);
      else check("R1 stall", load_stall, exp_st);
      check("R2 freeze", {pc_freeze, fd_freeze}, exp_st * 3);
      check("R3 ctrl", exe_ctrl_next, exp_st == 1 ? 0 : int'(cw));
    end

    // Small pipeline run: load r2; and r4,r2,r5; or r4,r4,r2; add r6,r4,r2.
    begin
      instr_t prog [4];
      instr_t nop_i, ifid, idex, exmem, memwb;
      int pc, stalls, stall_at_i1;
      logic [1:0] got_a [4];
      logic [1:0] got_b [4];
      int seen [4];
      nop_i = '0;
      prog[0] = '{v:1, rd:2, rs1:1, rs2:0, we:1, ld:1};
      prog[1] = '{v:1, rd:4, rs1:2, rs2:5, we:1, ld:0};
      prog[2] = '{v:1, rd:4, rs1:4, rs2:2, we:1, ld:0};
      prog[3] = '{v:1, rd:6, rs1:4, rs2:2, we:1, ld:0};
      ifid = nop_i; idex = nop_i; exmem = nop_i; memwb = nop_i;
      pc = 0; stalls = 0; stall_at_i1 = 0;
      for (int k = 0; k < 4; k++) begin seen[k] = 0; got_a[k] = '0; got_b[k] = '0; end
      for (int cyc = 0; cyc < 12; cyc++) begin
        @(negedge clk);
        dec_src1 = ifid.rs1; dec_src2 = ifid.rs2; dec_ctrl = {CW{ifid.v}};
        exe_src1 = idex.rs1; exe_src2 = idex.rs2;
        exe_dst = idex.rd; exe_wen = idex.we; exe_load = idex.ld;
        mem_dst = exmem.rd; mem_wen = exmem.we;
        wb_dst = memwb.rd; wb_wen = memwb.we;
        #2;
        for (int k = 1; k < 4; k++)
          if (idex.v && idex == prog[k]) begin seen[k]++; got_a[k] = opa_sel; got_b[k] = opb_sel; end
        if (load_stall) begin
          stalls++;
          if (ifid == prog[1]) stall_at_i1 = 1;
        end
        memwb = exmem;
        exmem = idex;
        if (load_stall) idex = nop_i;
        else begin
          idex = ifid;
          ifid = (pc < 4) ? prog[pc] : nop_i;
          pc++;
        end
      end
      check("R10 stall count", stalls, 1);
      check("R10 stall on consumer", stall_at_i1, 1);
      check("R10 consumer once in exe", seen[1], 1);
      check("R10 load data via writeback bypass", got_a[1], 1);
      check("R10 unrelated operand", got_b[1], 0);
      check("R10 second consumer young result", got_a[2], 2);
      check("R10 second consumer load written back", got_b[2], 0);
      check("R10 youngest of two producers", got_a[3], 2);
      check("R10 third consumer regfile", got_b[3], 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule